// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block derives two clock outputs from a single fast master clock. The first, the ring clock, is a square wave whose full period is set by a 4-bit period code in steps of 2 ms. Code 0 holds the ring clock static high and code 15 holds it static low. An external divide-by-two stage is expected to halve this output before it reaches a ring input. The second output, the channel clock, is picked by a 2-bit select. The choices are a static high level, a fast clock (half the master rate), or one of two slow clocks. The fast choice is honoured only while at least one channel power-up flag is set; otherwise the output parks high.

The master clock runs at twice the fast channel-clock rate, which gives 32.768 MHz for a 16.384 MHz fast clock. Every output rate comes from integer division of that master clock. `UNIT_CYC` is the number of master cycles in 1 ms. `FAST_HALF`, `MID_HALF` and `SLOW_HALF` are the half-period lengths of the three running channel-clock choices, in master cycles. Both outputs change their rate only at phase boundaries, so a reprogramming never produces a shortened pulse.

Ring clock FSM states:
- `RG_HOLD_HI`: the output is static high.
- `RG_HOLD_LO`: the output is static low.
- `RG_RUN_HI`: the output is high in a running period.
- `RG_RUN_LO`: the output is low in a running period.

Ring clock transitions:
- hold-to-hold switches immediately when the code changes between 0 and 15.
- hold-to-run goes to `RG_RUN_HI` when a code from 1 to 14 appears.
- high-to-low leaves `RG_RUN_HI` when its counter expires.
- period-end leaves `RG_RUN_LO` when its counter expires. It samples the code and goes to `RG_RUN_HI`, `RG_HOLD_HI` or `RG_HOLD_LO`.

Channel clock FSM states:
- `CC_PARK`: the output is static high.
- `CC_HI`: the high phase of a running clock.
- `CC_LO`: the low phase of a running clock.

Channel clock transitions:
- start goes from `CC_PARK` to `CC_LO` when a running choice becomes effective.
- toggle goes between `CC_HI` and `CC_LO` at counter expiry, when a running choice is still effective.
- park goes to `CC_PARK` at counter expiry, when the effective choice is static.

Top module: `ckgen_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both `ring_clk_o` and `chan_clk_o` are high.
- R2: Ring code 0 (binary 0000) holds `ring_clk_o` constantly high once the running period ends.
- R3: Ring code 15 (binary 1111) holds `ring_clk_o` constantly low once the running period ends. `ring_clk_o` never rises while code 15 is applied.
- R4: For a ring code T from 1 to 14, `ring_clk_o` is high for exactly T×UNIT_CYC master cycles, then low for T×UNIT_CYC master cycles. This gives a period of 2T ms with a 50% duty cycle.
- R5: A new ring code is taken only at a period boundary, which is the rising edge of `ring_clk_o`, or immediately when leaving a hold level. A period already in progress completes both of its phases at the old length.
- R6: Channel select 00 holds `chan_clk_o` high.
- R7: Channel select 01 with at least one `chan_pwr_i` bit set makes `chan_clk_o` high for FAST_HALF cycles and low for FAST_HALF cycles.
- R8: Channel select 01 with every `chan_pwr_i` bit clear parks `chan_clk_o` high. `chan_clk_o` never falls while the effective choice is static.
- R9: Channel select 10 gives high and low phases of MID_HALF cycles. Channel select 11 gives high and low phases of SLOW_HALF cycles.
- R10: A change of channel select, or of channel power, takes effect at the next phase boundary. A phase already in progress keeps its old length, and `chan_clk_o` changes only at a phase boundary or when leaving park.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 2× the fast channel-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ring_t_i | input | 4 | Ring period code: 0 static high, 15 static low, 1..14 period of T×2 ms |
| chan_sel_i | input | 2 | Channel clock select: 00 static high, 01 fast, 10 mid, 11 slow |
| chan_pwr_i | input | NCH | Per-channel power-up flags |
| ring_clk_o | output | 1 | Ring clock output |
| chan_clk_o | output | 1 | Channel clock output |

## Verification
The hardest situation to reach is a rate change that arrives in the middle of a running phase. To detect a runt pulse, the bench must know exactly where in the phase the change landed. The stimulus first locks onto a rising edge seen on the output, then changes the code or select a fixed number of cycles later, while it keeps counting the phase in progress. A second hard case is power dropping while the fast clock runs: the output must finish its phase and then park, which the bench brings about by clearing every power flag while the fast clock is running.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;

    typedef enum logic [1:0] {
        RG_HOLD_HI = 2'd0,
        RG_HOLD_LO = 2'd1,
        RG_RUN_HI  = 2'd2,
        RG_RUN_LO  = 2'd3
    } ring_state_t;

    typedef enum logic [1:0] {
        CC_PARK = 2'd0,
        CC_HI   = 2'd1,
        CC_LO   = 2'd2
    } cc_state_t;

    localparam logic [3:0] RING_CODE_HIGH = 4'h0;
    localparam logic [3:0] RING_CODE_LOW  = 4'hF;

    localparam logic [1:0] CSEL_STATIC = 2'b00;
    localparam logic [1:0] CSEL_FAST   = 2'b01;
    localparam logic [1:0] CSEL_MID    = 2'b10;
    localparam logic [1:0] CSEL_SLOW   = 2'b11;

endpackage

// File: rtl/ckgen_ring_fsm.sv
module ckgen_ring_fsm
    import ckgen_pkg::*;
#(
    parameter int UNIT_CYC = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] t_code,
    output logic       ring_o,
    output logic       at_end_o
);
    localparam int MAX_PHASE = 14 * UNIT_CYC;
    localparam int CW        = $clog2(MAX_PHASE + 1);

    ring_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [3:0]    tcur_q, tcur_d;

    logic          code_hi, code_lo, cnt_zero;
    logic [CW-1:0] load_new, load_cur;

    assign code_hi  = (t_code == RING_CODE_HIGH);
    assign code_lo  = (t_code == RING_CODE_LOW);
    assign cnt_zero = (cnt_q == '0);
    assign load_new = CW'(t_code) * CW'(UNIT_CYC) - CW'(1);
    assign load_cur = CW'(tcur_q) * CW'(UNIT_CYC) - CW'(1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tcur_d  = tcur_q;
        unique case (state_q)
            RG_HOLD_HI: begin
                cnt_d = '0;
                if (code_lo) begin
                    state_d = RG_HOLD_LO;
                end else if (!code_hi) begin
                    state_d = RG_RUN_HI;
                    cnt_d   = load_new;
                    tcur_d  = t_code;
                end
            end
            RG_HOLD_LO: begin
                cnt_d = '0;
                if (code_hi) begin
                    state_d = RG_HOLD_HI;
                end else if (!code_lo) begin
                    state_d = RG_RUN_HI;
                    cnt_d   = load_new;
                    tcur_d  = t_code;
                end
            end
            RG_RUN_HI: begin
                if (cnt_zero) begin
                    state_d = RG_RUN_LO;
                    cnt_d   = load_cur;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            RG_RUN_LO: begin
                if (cnt_zero) begin
                    if (code_hi) begin
                        state_d = RG_HOLD_HI;
                        cnt_d   = '0;
                    end else if (code_lo) begin
                        state_d = RG_HOLD_LO;
                        cnt_d   = '0;
                    end else begin
                        state_d = RG_RUN_HI;
                        cnt_d   = load_new;
                        tcur_d  = t_code;
                    end
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = RG_HOLD_HI;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RG_HOLD_HI;
            cnt_q   <= '0;
            tcur_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tcur_q  <= tcur_d;
        end
    end

    always_comb begin
        ring_o   = (state_q == RG_HOLD_HI) || (state_q == RG_RUN_HI);
        at_end_o = cnt_zero && ((state_q == RG_RUN_HI) || (state_q == RG_RUN_LO));
    end

endmodule

// File: rtl/ckgen_chan_mode.sv
module ckgen_chan_mode
    import ckgen_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int FAST_HALF = 1,
    parameter int MID_HALF  = 32,
    parameter int SLOW_HALF = 64,
    parameter int HW        = 7
) (
    input  logic [1:0]     sel,
    input  logic [NCH-1:0] pwr,
    output logic           running_o,
    output logic [HW-1:0]  half_o
);
    logic any_up;

    generate
        if (NCH == 1) begin : g_single
            assign any_up = pwr[0];
        end else begin : g_multi
            assign any_up = |pwr;
        end
    endgenerate

    always_comb begin
        running_o = 1'b0;
        half_o    = HW'(FAST_HALF);
        unique case (sel)
            CSEL_STATIC: running_o = 1'b0;
            CSEL_FAST: begin
                running_o = any_up;
                half_o    = HW'(FAST_HALF);
            end
            CSEL_MID: begin
                running_o = 1'b1;
                half_o    = HW'(MID_HALF);
            end
            CSEL_SLOW: begin
                running_o = 1'b1;
                half_o    = HW'(SLOW_HALF);
            end
            default: running_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ckgen_chan_fsm.sv
module ckgen_chan_fsm
    import ckgen_pkg::*;
#(
    parameter int HW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          running,
    input  logic [HW-1:0] half,
    output logic          chan_o,
    output logic          at_end_o,
    output logic          parked_o
);
    cc_state_t     state_q, state_d;
    logic [HW-1:0] cnt_q, cnt_d;
    logic          cnt_zero;
    logic [HW-1:0] load_val;

    assign cnt_zero = (cnt_q == '0);
    assign load_val = half - HW'(1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CC_PARK: begin
                cnt_d = '0;
                if (running) begin
                    state_d = CC_LO;
                    cnt_d   = load_val;
                end
            end
            CC_HI: begin
                if (cnt_zero) begin
                    state_d = running ? CC_LO : CC_PARK;
                    cnt_d   = running ? load_val : '0;
                end else begin
                    cnt_d = cnt_q - HW'(1);
                end
            end
            CC_LO: begin
                if (cnt_zero) begin
                    state_d = running ? CC_HI : CC_PARK;
                    cnt_d   = running ? load_val : '0;
                end else begin
                    cnt_d = cnt_q - HW'(1);
                end
            end
            default: begin
                state_d = CC_PARK;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CC_PARK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        chan_o   = (state_q != CC_LO);
        parked_o = (state_q == CC_PARK);
        at_end_o = cnt_zero && (state_q != CC_PARK);
    end

endmodule

// File: rtl/ckgen_top.sv
module ckgen_top #(
    parameter int NCH       = 2,
    parameter int UNIT_CYC  = 32768,
    parameter int FAST_HALF = 1,
    parameter int MID_HALF  = 32,
    parameter int SLOW_HALF = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [3:0]     ring_t_i,
    input  logic [1:0]     chan_sel_i,
    input  logic [NCH-1:0] chan_pwr_i,
    output logic           ring_clk_o,
    output logic           chan_clk_o
);
    localparam int HALF_A   = (FAST_HALF > MID_HALF) ? FAST_HALF : MID_HALF;
    localparam int HALF_MAX = (HALF_A > SLOW_HALF) ? HALF_A : SLOW_HALF;
    localparam int HW       = $clog2(HALF_MAX + 1);

    logic          ring_end;
    logic          chan_end;
    logic          chan_parked;
    logic          chan_running;
    logic [HW-1:0] chan_half;

    ckgen_ring_fsm #(.UNIT_CYC(UNIT_CYC)) ring_i (
        .clk     (clk),
        .rst     (rst),
        .t_code  (ring_t_i),
        .ring_o  (ring_clk_o),
        .at_end_o(ring_end)
    );

    ckgen_chan_mode #(
        .NCH      (NCH),
        .FAST_HALF(FAST_HALF),
        .MID_HALF (MID_HALF),
        .SLOW_HALF(SLOW_HALF),
        .HW       (HW)
    ) mode_i (
        .sel      (chan_sel_i),
        .pwr      (chan_pwr_i),
        .running_o(chan_running),
        .half_o   (chan_half)
    );

    ckgen_chan_fsm #(.HW(HW)) chan_i (
        .clk     (clk),
        .rst     (rst),
        .running (chan_running),
        .half    (chan_half),
        .chan_o  (chan_clk_o),
        .at_end_o(chan_end),
        .parked_o(chan_parked)
    );

endmodule

// File: rtl/ckgen_chk.sv
module ckgen_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [3:0]     t_code,
    input logic [1:0]     sel,
    input logic [NCH-1:0] pwr,
    input logic           ring_o,
    input logic           chan_o,
    input logic           ring_end,
    input logic           chan_end,
    input logic           chan_parked
);
    logic pwr_any;
    assign pwr_any = |pwr;

    // R1
    reset_high_chk: assert property (@(posedge clk) rst |=> (ring_o && chan_o));

    // R3
    ring_no_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ring_o) |-> ($past(t_code) != 4'hF));

    // R5
    ring_fall_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ring_o) |-> ($past(ring_end) || ($past(t_code) == 4'hF)));

    // R8
    chan_no_fall_static_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(chan_o) |-> $past((sel != 2'b00) && !((sel == 2'b01) && !pwr_any)));

    // R10
    chan_edge_at_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(chan_o) |-> ($past(chan_end) || $past(chan_parked)));

endmodule

bind ckgen_top ckgen_chk #(.NCH(NCH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .t_code     (ring_t_i),
    .sel        (chan_sel_i),
    .pwr        (chan_pwr_i),
    .ring_o     (ring_clk_o),
    .chan_o     (chan_clk_o),
    .ring_end   (ring_end),
    .chan_end   (chan_end),
    .chan_parked(chan_parked)
);

// File: tb/ckgen_top_tb_top.sv
module ckgen_top_tb_top;
    localparam int NCH  = 2;
    localparam int U    = 4;
    localparam int FH   = 1;
    localparam int MH   = 3;
    localparam int SH   = 7;

    logic           clk = 1'b0;
    logic           rst;
    logic [3:0]     ring_t;
    logic [1:0]     csel;
    logic [NCH-1:0] cpwr;
    logic           ring_clk, chan_clk;

    int  errs = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    ckgen_top #(.NCH(NCH), .UNIT_CYC(U), .FAST_HALF(FH), .MID_HALF(MH), .SLOW_HALF(SH)) dut_i (
        .clk(clk), .rst(rst), .ring_t_i(ring_t), .chan_sel_i(csel), .chan_pwr_i(cpwr),
        .ring_clk_o(ring_clk), .chan_clk_o(chan_clk)
    );

    function automatic int ring_half(input int t);
        return t * U;
    endfunction

    function automatic int chan_half(input logic [1:0] s, input logic [NCH-1:0] p);
        case (s)
            2'b01:   return (p != '0) ? FH : 0;
            2'b10:   return MH;
            2'b11:   return SH;
            default: return 0;
        endcase
    endfunction

    function automatic logic pick(input bit which);
        return which ? chan_clk : ring_clk;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic find_rise(input bit which);
        logic prev;
        @(negedge clk);
        prev = pick(which);
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (!prev && pick(which)) return;
            prev = pick(which);
        end
    endtask

    task automatic count_level(input bit which, input logic lvl, inout int cnt);
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (pick(which) != lvl) return;
            cnt++;
        end
    endtask

    task automatic measure(input bit which, output int hi, output int lo);
        find_rise(which);
        hi = 1;
        count_level(which, 1'b1, hi);
        lo = 1;
        count_level(which, 1'b0, lo);
    endtask

    task automatic static_check(input bit which, input logic lvl, input int settle,
                                input string req);
        int bad = 0;
        repeat (settle) @(negedge clk);
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if (pick(which) != lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int hi, lo, t, e, cnt;
        void'($urandom(32'd2024));
        rst = 1'b1; ring_t = 4'h0; csel = 2'b00; cpwr = '0;
        repeat (3) @(negedge clk);
        check(ring_clk && chan_clk, "R1 reset levels", {ring_clk, chan_clk}, 3);
        rst = 1'b0;
        @(negedge clk);
        check(ring_clk && chan_clk, "R1 after release", {ring_clk, chan_clk}, 3);

        // R2 static high
        static_check(1'b0, 1'b1, 8, "R2 code0 high");

        // R4 directed extremes and random codes
        ring_t = 4'd1;
        measure(1'b0, hi, lo);
        check(hi == ring_half(1) && lo == ring_half(1), "R4 T=1", hi * 1000 + lo, ring_half(1) * 1001);
        ring_t = 4'd14;
        measure(1'b0, hi, lo);
        check(hi == ring_half(14) && lo == ring_half(14), "R4 T=14", hi * 1000 + lo, ring_half(14) * 1001);
        for (int k = 0; k < 6; k++) begin
            t = 1 + int'($urandom_range(13));
            ring_t = 4'(t);
            measure(1'b0, hi, lo);
            check(hi == ring_half(t) && lo == ring_half(t), "R4 random T", hi * 1000 + lo, ring_half(t) * 1001);
        end

        // R5 change mid high phase: current period keeps old length
        ring_t = 4'd3;
        find_rise(1'b0);
        find_rise(1'b0);
        cnt = 1;
        repeat (2) begin @(negedge clk); if (ring_clk) cnt++; end
        ring_t = 4'd9;
        count_level(1'b0, 1'b1, cnt);
        check(cnt == ring_half(3), "R5 high phase old length", cnt, ring_half(3));
        lo = 1;
        count_level(1'b0, 1'b0, lo);
        check(lo == ring_half(3), "R5 low phase old length", lo, ring_half(3));
        hi = 1;
        count_level(1'b0, 1'b1, hi);
        check(hi == ring_half(9), "R5 next period new length", hi, ring_half(9));

        // R3 static low, then R2 again from low hold
        ring_t = 4'hF;
        static_check(1'b0, 1'b0, 2 * ring_half(14) + 10, "R3 code15 low");
        ring_t = 4'h0;
        static_check(1'b0, 1'b1, 2 * ring_half(14) + 10, "R2 code0 from low hold");

        // R6 static select
        csel = 2'b00;
        static_check(1'b1, 1'b1, 4, "R6 sel00 high");
        // R8 fast with no power
        csel = 2'b01; cpwr = '0;
        static_check(1'b1, 1'b1, 4, "R8 fast unpowered high");
        // R7 fast with one channel powered each
        cpwr = 2'b01;
        measure(1'b1, hi, lo);
        check(hi == FH && lo == FH, "R7 fast pwr ch0", hi * 1000 + lo, FH * 1001);
        cpwr = 2'b10;
        measure(1'b1, hi, lo);
        check(hi == FH && lo == FH, "R7 fast pwr ch1", hi * 1000 + lo, FH * 1001);
        // R8 power drops while fast runs
        cpwr = '0;
        static_check(1'b1, 1'b1, 4, "R8 power dropped parks high");
        // R9 mid and slow
        csel = 2'b10;
        measure(1'b1, hi, lo);
        check(hi == MH && lo == MH, "R9 sel10", hi * 1000 + lo, MH * 1001);
        csel = 2'b11;
        measure(1'b1, hi, lo);
        check(hi == SH && lo == SH, "R9 sel11", hi * 1000 + lo, SH * 1001);

        // R10 select change mid phase
        find_rise(1'b1);
        cnt = 1;
        repeat (2) begin @(negedge clk); if (chan_clk) cnt++; end
        csel = 2'b10;
        count_level(1'b1, 1'b1, cnt);
        check(cnt == SH, "R10 phase in progress keeps length", cnt, SH);
        lo = 1;
        count_level(1'b1, 1'b0, lo);
        check(lo == MH, "R10 next phase new length", lo, MH);

        // random channel trials
        for (int k = 0; k < 8; k++) begin
            csel = 2'($urandom_range(3));
            cpwr = NCH'($urandom_range(3));
            e = chan_half(csel, cpwr);
            if (e == 0) begin
                static_check(1'b1, 1'b1, 2 * SH + 4, "R8 random static");
            end else begin
                measure(1'b1, hi, lo);
                check(hi == e && lo == e, "R9 random running", hi * 1000 + lo, e * 1001);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule